// File: doc/BRIEF.md
# Hot-Swap Fault Supervisor

This block is the digital supervisor of a high-side hot-swap switch. Each clock it takes a sampled supply-voltage code, an output-voltage code and a load-current code, together with an enable input. It drives a registered gate-enable output for the pass switch. It raises an active-low fault flag when a protection path trips, and an active-low switch-failure flag when current keeps flowing while the switch is commanded off.

Three protection paths feed one latched fault. The power path compares the product of output voltage and current against a fixed limit. The overcurrent path compares current against a programmed threshold. Each of these two paths runs its own delay counter, which restarts whenever its condition drops. A short-circuit comparison trips with no delay at all. The supply must clear an undervoltage window that has hysteresis before the gate may turn on. The two counters' expired flags stay visible after a trip, so the cause can be read out. Dropping enable clears the fault and both counters. The switch-failure latch is cleared only by reset, which stands for a power cycle.

Top module: `hsw_supervisor`

## Requirements
- R1: After reset, gate_on is 0, fault_n and swfail_n are 1, and both expired flags are 0.
- R2: gate_on rises on the second clock edge after vsup first reaches UV_ON (code 105) with en high and no fault latched. It is 0 one edge after en is sampled low.
- R3: Once on, the supply-good state is kept for any vsup at or above UV_OFF (code 71). It is lost one edge after vsup drops below 71, which turns the gate off one edge later. From the off state, a vsup below 105 does not turn the gate on.
- R4: With pwr_dly = T (nonzero), vout*iload above PWR_LIMIT (9200) for T consecutive edges drives fault_n low and gate_on low on the T-th edge. At that point pwr_tmr_exp is 1 and oc_tmr_exp is 0.
- R5: If a delay condition is absent on any one edge, its counter restarts, so a fresh full window of T consecutive edges is needed to trip.
- R6: With oc_dly = T, iload above oc_thr for T consecutive edges drives fault_n low and gate_on low on the T-th edge, and sets oc_tmr_exp to 1. A value of 0 acts as 1.
- R7: iload above SC_THR (440) with en high drives gate_on and fault_n low on the next edge. Both expired flags stay 0.
- R8: en sampled low clears the latched fault and both expired flags on that edge. After en returns high, the gate turns on again on the next edge.
- R9: pwr_dly = 0 turns off the power path; power above the limit then never trips, while the overcurrent path still does.
- R10: pwr_dly, oc_dly and oc_thr are captured only on edges where gate_on is 0. Changes made while the gate is on take effect only after the next off period.
- R11: When iload is above SWF_THR (6) while gate_on is 0 and SETTLE edges have passed since turn-off, swfail_n latches low. Current seen earlier in the settling time is ignored. Toggling en does not clear it; reset does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power cycle) |
| en | input | 1 | Enable, active high |
| vsup | input | VW | Supply voltage code |
| vout | input | VW | Output voltage code |
| iload | input | IW | Load current code |
| pwr_dly | input | TW | Power delay terminal count, 0 disables the power path |
| oc_dly | input | TW | Overcurrent delay terminal count |
| oc_thr | input | IW | Overcurrent threshold code |
| gate_on | output | 1 | Gate enable for the pass switch |
| fault_n | output | 1 | Latched protection fault, active low |
| swfail_n | output | 1 | Latched switch-failure flag, active low |
| pwr_tmr_exp | output | 1 | Power delay counter expired |
| oc_tmr_exp | output | 1 | Overcurrent delay counter expired |

## Verification
A short and an en drop each take effect on the first edge. A delay path trips on the T-th consecutive edge of its condition. A supply rise turns the gate on after two edges, because the supply-good state is itself a register. A switch failure latches SETTLE+2 edges after en falls: one edge for the gate to drop, then SETTLE settling edges, then the edge that samples the current. Each directed task changes its inputs 2 ns after an edge, steps the exact number of edges the requirement gives, and samples there. For timers and settling it also samples one edge earlier, which shows that no result arrives early.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  localparam int NUM_TMR = 2;
  localparam int TMR_PWR = 0;
  localparam int TMR_OC  = 1;
endpackage

// File: rtl/hsw_uvlo.sv
module hsw_uvlo #(
  parameter int VW       = 8,
  parameter int ON_CODE  = 105,
  parameter int OFF_CODE = 71
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [VW-1:0] vsup,
  output logic          ok
);
  localparam logic [VW-1:0] ON_V  = VW'(ON_CODE);
  localparam logic [VW-1:0] OFF_V = VW'(OFF_CODE);

  always_ff @(posedge clk) begin
    if (rst)                     ok <= 1'b0;
    else if (!ok && vsup >= ON_V) ok <= 1'b1;
    else if (ok && vsup < OFF_V)  ok <= 1'b0;
  end

  // R3: inside the hysteresis window the state is held
  a_r3_hold_in_window: assert property (@(posedge clk) disable iff (rst)
    (ok && vsup >= OFF_V) |=> ok);
  a_r3_no_early_on: assert property (@(posedge clk) disable iff (rst)
    (!ok && vsup < ON_V) |=> !ok);
endmodule

// File: rtl/hsw_delay_timer.sv
module hsw_delay_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          arm,
  input  logic [TW-1:0] term,
  output logic          trip,
  output logic          expired
);
  logic [TW-1:0] cnt;
  logic [TW:0]   nxt;
  logic          hit;

  always_comb begin
    nxt  = {1'b0, cnt} + (TW+1)'(1);
    hit  = nxt >= {1'b0, term};
    trip = arm && !clr && !expired && hit;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (trip) begin
      cnt     <= '0;
      expired <= 1'b1;
    end else if (arm && !expired) begin
      cnt <= nxt[TW-1:0];
    end else if (!arm) begin
      cnt <= '0;
    end
  end

  // R5: a missing condition restarts the window
  a_r5_drop_restarts: assert property (@(posedge clk) disable iff (rst)
    !arm |=> (cnt == '0));
  // R8: clear wipes the counter and the expired flag
  a_r8_clear_wipes: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!expired && cnt == '0));
endmodule

// File: rtl/hsw_swfail.sv
module hsw_swfail #(
  parameter int IW     = 10,
  parameter int THR    = 6,
  parameter int SETTLE = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gate_on,
  input  logic [IW-1:0] iload,
  output logic          failed
);
  localparam int SW = (SETTLE < 1) ? 1 : $clog2(SETTLE + 1);
  localparam logic [SW-1:0] SETTLE_C = SW'(SETTLE);
  localparam logic [IW-1:0] THR_C    = IW'(THR);

  logic [SW-1:0] settle_cnt;
  logic          settled;

  assign settled = (settle_cnt == SETTLE_C);

  always_ff @(posedge clk) begin
    if (rst || gate_on)  settle_cnt <= '0;
    else if (!settled)   settle_cnt <= settle_cnt + SW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)                                       failed <= 1'b0;
    else if (!gate_on && settled && iload > THR_C) failed <= 1'b1;
  end

  // R11: only reset clears the latch
  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    failed |=> failed);
  a_r11_only_when_off: assert property (@(posedge clk) disable iff (rst)
    $rose(failed) |-> $past(!gate_on));
endmodule

// File: rtl/hsw_supervisor.sv
module hsw_supervisor
  import hsw_pkg::*;
#(
  parameter int IW        = 10,
  parameter int VW        = 8,
  parameter int TW        = 12,
  parameter int PWR_LIMIT = 9200,
  parameter int SC_THR    = 440,
  parameter int SWF_THR   = 6,
  parameter int UV_ON     = 105,
  parameter int UV_OFF    = 71,
  parameter int SETTLE    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [VW-1:0] vsup,
  input  logic [VW-1:0] vout,
  input  logic [IW-1:0] iload,
  input  logic [TW-1:0] pwr_dly,
  input  logic [TW-1:0] oc_dly,
  input  logic [IW-1:0] oc_thr,
  output logic          gate_on,
  output logic          fault_n,
  output logic          swfail_n,
  output logic          pwr_tmr_exp,
  output logic          oc_tmr_exp
);
  localparam int PW = IW + VW;
  localparam logic [PW-1:0] PWR_LIM_C = PW'(PWR_LIMIT);
  localparam logic [IW-1:0] SC_C      = IW'(SC_THR);

  logic          uv_ok;
  logic          gate_q, fault_q, fault_set, swf;
  logic          sc_hit;
  logic [PW-1:0] power;
  logic [TW-1:0] pwr_dly_q, oc_dly_q;
  logic [IW-1:0] oc_thr_q;
  logic [NUM_TMR-1:0] tmr_arm, tmr_trip, tmr_exp;
  logic [TW-1:0]      tmr_term [NUM_TMR];

  hsw_uvlo #(.VW(VW), .ON_CODE(UV_ON), .OFF_CODE(UV_OFF)) u_uvlo (
    .clk(clk), .rst(rst), .vsup(vsup), .ok(uv_ok));

  // settings are captured only while the switch is off
  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_dly_q <= '0;
      oc_dly_q  <= '0;
      oc_thr_q  <= '0;
    end else if (!gate_q) begin
      pwr_dly_q <= pwr_dly;
      oc_dly_q  <= oc_dly;
      oc_thr_q  <= oc_thr;
    end
  end

  always_comb begin
    power             = PW'(vout) * PW'(iload);
    sc_hit            = iload > SC_C;
    tmr_arm[TMR_PWR]  = (pwr_dly_q != '0) && (power > PWR_LIM_C) && !fault_q;
    tmr_arm[TMR_OC]   = (iload > oc_thr_q) && !fault_q;
    tmr_term[TMR_PWR] = pwr_dly_q;
    tmr_term[TMR_OC]  = oc_dly_q;
    fault_set         = en && !fault_q && ((|tmr_trip) || sc_hit);
  end

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    hsw_delay_timer #(.TW(TW)) u_tmr (
      .clk(clk), .rst(rst), .clr(!en), .arm(tmr_arm[g]), .term(tmr_term[g]),
      .trip(tmr_trip[g]), .expired(tmr_exp[g]));
  end

  always_ff @(posedge clk) begin
    if (rst || !en)     fault_q <= 1'b0;
    else if (fault_set) fault_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= en && uv_ok && !fault_q && !fault_set;
  end

  hsw_swfail #(.IW(IW), .THR(SWF_THR), .SETTLE(SETTLE)) u_swf (
    .clk(clk), .rst(rst), .gate_on(gate_q), .iload(iload), .failed(swf));

  assign gate_on     = gate_q;
  assign fault_n     = !fault_q;
  assign swfail_n    = !swf;
  assign pwr_tmr_exp = tmr_exp[TMR_PWR];
  assign oc_tmr_exp  = tmr_exp[TMR_OC];

  // R2: enable low forces the gate off on the next edge
  a_r2_en_gates: assert property (@(posedge clk) disable iff (rst)
    !en |=> !gate_on);
  // R7: a short turns the gate off on the next edge
  a_r7_short_kills_gate: assert property (@(posedge clk) disable iff (rst)
    (en && iload > SC_C) |=> (!gate_on && !fault_n));
  // R4: a latched fault keeps the gate off
  a_r4_fault_gate_off: assert property (@(posedge clk) disable iff (rst)
    !fault_n |-> !gate_on);
  // R8: enable low clears the fault
  a_r8_en_clears: assert property (@(posedge clk) disable iff (rst)
    !en |=> (fault_n && !pwr_tmr_exp && !oc_tmr_exp));
  // R10: settings frozen while the gate is on
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    gate_q |=> ($stable(oc_thr_q) && $stable(oc_dly_q) && $stable(pwr_dly_q)));
endmodule

// File: tb/hsw_supervisor_test.sv
module hsw_supervisor_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [7:0]  vsup = '0, vout = '0;
  logic [9:0]  iload = '0, oc_thr = 10'd160;
  logic [11:0] pwr_dly = 12'd8, oc_dly = 12'd5;
  logic        gate_on, fault_n, swfail_n, pwr_tmr_exp, oc_tmr_exp;
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  hsw_supervisor uut (
    .clk(clk), .rst(rst), .en(en), .vsup(vsup), .vout(vout), .iload(iload),
    .pwr_dly(pwr_dly), .oc_dly(oc_dly), .oc_thr(oc_thr),
    .gate_on(gate_on), .fault_n(fault_n), .swfail_n(swfail_n),
    .pwr_tmr_exp(pwr_tmr_exp), .oc_tmr_exp(oc_tmr_exp));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_fault();
    iload = '0;
    en = 1'b0;
    step(1);
    chk("R8 fault cleared", fault_n, 1);
    chk("R8 pwr flag cleared", pwr_tmr_exp, 0);
    chk("R8 oc flag cleared", oc_tmr_exp, 0);
    en = 1'b1;
    step(1);
    chk("R8 gate back on", gate_on, 1);
  endtask

  task automatic t_reset();
    step(3);
    rst = 1'b0;
    step(1);
    chk("R1 gate off", gate_on, 0);
    chk("R1 fault_n high", fault_n, 1);
    chk("R1 swfail_n high", swfail_n, 1);
    chk("R1 pwr flag low", pwr_tmr_exp, 0);
    chk("R1 oc flag low", oc_tmr_exp, 0);
  endtask

  task automatic t_power_up();
    vsup = 8'd120;
    step(3);
    chk("R2 en low keeps gate off", gate_on, 0);
    en = 1'b1;
    step(1);
    chk("R2 gate on after en", gate_on, 1);
    en = 1'b0;
    step(1);
    chk("R2 gate off after en low", gate_on, 0);
    vsup = 8'd0;
    step(2);
    vsup = 8'd120;
    en = 1'b1;
    step(1);
    chk("R2 not on after one edge", gate_on, 0);
    step(1);
    chk("R2 on after second edge", gate_on, 1);
  endtask

  task automatic t_uvlo();
    vsup = 8'd90;
    step(3);
    chk("R3 stays on inside window", gate_on, 1);
    vsup = 8'd70;
    step(1);
    chk("R3 one edge after drop", gate_on, 1);
    step(1);
    chk("R3 off after drop", gate_on, 0);
    vsup = 8'd90;
    step(3);
    chk("R3 no turn-on below on level", gate_on, 0);
    vsup = 8'd120;
    step(2);
    chk("R3 on after rise", gate_on, 1);
  endtask

  task automatic t_power();
    vout  = 8'd120;
    iload = 10'd80;
    step(7);
    chk("R4 no trip before window", fault_n, 1);
    step(1);
    chk("R4 fault after window", fault_n, 0);
    chk("R4 gate off", gate_on, 0);
    chk("R4 pwr flag", pwr_tmr_exp, 1);
    chk("R4 oc flag", oc_tmr_exp, 0);
    clear_fault();
  endtask

  task automatic t_restart();
    vout  = 8'd120;
    iload = 10'd80;
    step(5);
    iload = 10'd76;
    step(1);
    iload = 10'd80;
    step(7);
    chk("R5 window restarted", fault_n, 1);
    step(1);
    chk("R5 trip after full window", fault_n, 0);
    chk("R5 pwr flag", pwr_tmr_exp, 1);
    clear_fault();
  endtask

  task automatic t_oc();
    vout  = 8'd0;
    iload = 10'd170;
    step(4);
    chk("R6 no trip before window", fault_n, 1);
    step(1);
    chk("R6 fault after window", fault_n, 0);
    chk("R6 gate off", gate_on, 0);
    chk("R6 oc flag", oc_tmr_exp, 1);
    chk("R6 pwr flag", pwr_tmr_exp, 0);
    clear_fault();
  endtask

  task automatic t_short();
    vout  = 8'd0;
    iload = 10'd450;
    step(1);
    chk("R7 gate off at once", gate_on, 0);
    chk("R7 fault low", fault_n, 0);
    chk("R7 pwr flag low", pwr_tmr_exp, 0);
    chk("R7 oc flag low", oc_tmr_exp, 0);
    clear_fault();
  endtask

  task automatic t_current_only();
    en = 1'b0;
    pwr_dly = 12'd0;
    step(1);
    en = 1'b1;
    step(1);
    vout  = 8'd120;
    iload = 10'd100;
    step(20);
    chk("R9 no power trip", fault_n, 1);
    chk("R9 gate still on", gate_on, 1);
    iload = 10'd170;
    step(5);
    chk("R9 overcurrent still trips", fault_n, 0);
    chk("R9 oc flag", oc_tmr_exp, 1);
    chk("R9 pwr flag", pwr_tmr_exp, 0);
    pwr_dly = 12'd8;
    vout = 8'd0;
    clear_fault();
  endtask

  task automatic t_cfg();
    oc_thr = 10'd20;
    oc_dly = 12'd2;
    vout   = 8'd0;
    iload  = 10'd100;
    step(10);
    chk("R10 new threshold ignored while on", fault_n, 1);
    iload = 10'd0;
    en = 1'b0;
    step(1);
    en = 1'b1;
    step(1);
    iload = 10'd100;
    step(1);
    chk("R10 new delay in use", fault_n, 1);
    step(1);
    chk("R10 new settings trip", fault_n, 0);
    chk("R10 oc flag", oc_tmr_exp, 1);
    oc_thr = 10'd160;
    oc_dly = 12'd5;
    clear_fault();
  endtask

  task automatic t_swfail();
    en = 1'b0;
    iload = 10'd10;
    step(5);
    chk("R11 ignored while settling", swfail_n, 1);
    step(1);
    chk("R11 latched after settling", swfail_n, 0);
    iload = 10'd0;
    en = 1'b1;
    step(2);
    chk("R11 survives en high", swfail_n, 0);
    en = 1'b0;
    step(2);
    chk("R11 survives en low", swfail_n, 0);
    rst = 1'b1;
    step(1);
    rst = 1'b0;
    step(1);
    chk("R11 cleared by reset", swfail_n, 1);
  endtask

  initial begin
    t_reset();
    t_power_up();
    t_uvlo();
    t_power();
    t_restart();
    t_oc();
    t_short();
    t_current_only();
    t_cfg();
    t_swfail();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule